// File: doc/BRIEF.md
# ADC Conversion Clock Tick Generator

This block supplies the timebases that an analogue-to-digital converter controller needs. It runs on a single parent clock and produces three single-cycle enable pulses on that clock. None of them is a derived clock. The first is a main conversion tick, made by dividing the parent clock by a programmable ratio. The second is a 10 µs settle tick, made by counting main ticks. The third is a 1 ms wait tick, made by counting 10 µs ticks. The three dividers form a cascade, so each slower tick always coincides with a pulse of the tick that feeds it.

Software computes the divide values and writes them together as one 32-bit configuration word. Each field holds its ratio minus one. A write restarts all three counters, so the new ratios begin from a clean phase.

Two field arrangements are available, chosen by a synthesis-time parameter:
- **Wide arrangement:** an 8-bit main field at bits 7:0, an 8-bit settle field at bits 15:8, and a 16-bit wait field at bits 31:16.
- **Narrow arrangement:** a 6-bit main field at bits 5:0 and a 16-bit settle field at bits 31:16. It has no wait divider.

Top module: `adc_tick_gen`

## Requirements
- R1: While reset is asserted all three tick outputs are low. Reset clears the configuration word to zero, so after reset every enabled divider ratio is one.
- R2: With main field value M, the main tick pulses once every M+1 parent cycles. The main field is bits 7:0 in the wide arrangement and bits 5:0 in the narrow one.
- R3: A field value of zero divides by one: the divider's output pulses on every input tick it receives.
- R4: With settle field value T, the settle tick pulses once every T+1 main ticks, always in the same cycle as a main tick. The settle field is bits 15:8 (wide) or bits 31:16 (narrow).
- R5: In the wide arrangement, with wait field value S at bits 31:16, the wait tick pulses once every S+1 settle ticks, always in the same cycle as a settle tick.
- R6: A configuration write clears every counter. Counting cycles from 0 at the first cycle after the write's clock edge, a tick with total ratio P pulses in cycle n exactly when (n+1) mod P = 0.
- R7: In the narrow arrangement the wait tick stays low, and bits 15:6 of the configuration word have no effect.
- R8: A main field of 255 in the wide arrangement gives a main ratio of 256. A main field of 63 in the narrow arrangement gives a ratio of 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_data | input | 32 | Configuration word holding the divide fields (ratio minus one) |
| tick_main | output | 1 | Main conversion enable pulse |
| tick_10us | output | 1 | Settle timebase pulse |
| tick_1ms | output | 1 | Wait timebase pulse (constant low in the narrow arrangement) |

## Verification
The embedded assertions check these properties on every cycle:
- each counter stays within its current ratio;
- a counter holds its value when it sees no input tick;
- a counter clears after a write;
- the outputs stay quiet until the first edge after reset;
- each slower tick coincides with the tick that feeds it.

The exact period of each tick cannot be shown by a property. Nor can its phase after a write, the field positions of each arrangement, or the fact that reserved bits are ignored. The bench's scenarios show these. It sweeps small ratios in both arrangements side by side, rewrites the configuration while counters are mid-count, and runs the largest main ratios.

// File: rtl/adc_tick_pkg.sv
package adc_tick_pkg;

   typedef enum logic {
      LAYOUT_WIDE   = 1'b0,
      LAYOUT_NARROW = 1'b1
   } layout_e;

   function automatic int main_width(layout_e l);
      return (l == LAYOUT_WIDE) ? 8 : 6;
   endfunction

   function automatic int settle_lsb(layout_e l);
      return (l == LAYOUT_WIDE) ? 8 : 16;
   endfunction

   function automatic int settle_width(layout_e l);
      return (l == LAYOUT_WIDE) ? 8 : 16;
   endfunction

   function automatic bit has_wait(layout_e l);
      return (l == LAYOUT_WIDE);
   endfunction

   localparam int WAIT_LSB = 16;
   localparam int WAIT_W   = 16;

endpackage

// File: rtl/adc_tick_div.sv
module adc_tick_div #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic         in_tick,
   input  logic [W-1:0] ratio_m1,
   output logic         out_tick
);

   logic [W-1:0] cnt_q;
   logic         at_end;

   initial begin
      assert (W >= 1 && W <= 24)
         else $error("adc_tick_div: W out of range");
   end

   assign at_end   = (cnt_q == ratio_m1);
   assign out_tick = in_tick & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (in_tick) begin
         cnt_q <= at_end ? '0 : cnt_q + 1'b1;
      end
   end

   // R2: the counter never runs past the programmed ratio
   a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= ratio_m1);

   // R2: without an input tick the phase is frozen
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_tick && !restart) |=> $stable(cnt_q));

   // R6: a write restarts the phase
   a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == '0));

endmodule

// File: rtl/adc_tick_gen.sv
module adc_tick_gen
   import adc_tick_pkg::*;
#(
   parameter layout_e LAYOUT = LAYOUT_WIDE,
   parameter int      REG_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [REG_W-1:0] cfg_data,
   output logic             tick_main,
   output logic             tick_10us,
   output logic             tick_1ms
);

   localparam int  MAIN_W = main_width(LAYOUT);
   localparam int  SET_LSB = settle_lsb(LAYOUT);
   localparam int  SET_W  = settle_width(LAYOUT);
   localparam bit  HAS_WT = has_wait(LAYOUT);

   initial begin
      assert (SET_LSB + SET_W <= REG_W)
         else $error("adc_tick_gen: settle field exceeds register");
      assert (!HAS_WT || (WAIT_LSB + WAIT_W <= REG_W))
         else $error("adc_tick_gen: wait field exceeds register");
      assert (MAIN_W <= SET_LSB)
         else $error("adc_tick_gen: main and settle fields overlap");
   end

   logic [REG_W-1:0] cfg_q;
   logic             live_q;
   logic             unused_cfg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         live_q <= 1'b0;
      end else begin
         live_q <= 1'b1;
         if (cfg_wr) cfg_q <= cfg_data;
      end
   end

   assign unused_cfg = ^cfg_q;

   adc_tick_div #(.W(MAIN_W)) u_main (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (cfg_wr),
      .in_tick  (live_q),
      .ratio_m1 (cfg_q[MAIN_W-1:0]),
      .out_tick (tick_main)
   );

   adc_tick_div #(.W(SET_W)) u_settle (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (cfg_wr),
      .in_tick  (tick_main),
      .ratio_m1 (cfg_q[SET_LSB +: SET_W]),
      .out_tick (tick_10us)
   );

   generate
      if (HAS_WT) begin : g_wait
         adc_tick_div #(.W(WAIT_W)) u_wait (
            .clk      (clk),
            .rst_n    (rst_n),
            .restart  (cfg_wr),
            .in_tick  (tick_10us),
            .ratio_m1 (cfg_q[WAIT_LSB +: WAIT_W]),
            .out_tick (tick_1ms)
         );
      end else begin : g_no_wait
         assign tick_1ms = 1'b0;
      end
   endgenerate

   // R1: nothing pulses before the first edge after reset
   a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !live_q |-> !tick_main);

   // R4: settle tick only alongside a main tick
   a_r4_coincide: assert property (@(posedge clk) disable iff (!rst_n)
      tick_10us |-> tick_main);

   // R5: wait tick only alongside a settle tick
   a_r5_coincide: assert property (@(posedge clk) disable iff (!rst_n)
      tick_1ms |-> tick_10us);

endmodule

// File: tb/test_adc_tick_gen.sv
module test_adc_tick_gen;
   import adc_tick_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [31:0] cfg_data = '0;
   logic        w_main, w_us, w_ms;
   logic        n_main, n_us, n_ms;

   int checks = 0;
   int fails  = 0;
   int n      = 0;
   logic [31:0] cur = '0;
   bit done = 0;

   always #10 clk = ~clk;

   adc_tick_gen #(.LAYOUT(LAYOUT_WIDE)) i_adc_tick_gen (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
      .tick_main(w_main), .tick_10us(w_us), .tick_1ms(w_ms));

   adc_tick_gen #(.LAYOUT(LAYOUT_NARROW)) i_adc_tick_gen_alt (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
      .tick_main(n_main), .tick_10us(n_us), .tick_1ms(n_ms));

   task automatic check(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s cycle %0d cfg %h: actual %b expected %b", tag, n, cur, act, exp);
      end
   endtask

   function automatic logic due(input int period);
      return ((n + 1) % period) == 0;
   endfunction

   task automatic run(input int cycles);
      int wm, wt, ws, am, at;
      wm = int'(cur[7:0]) + 1;
      wt = wm * (int'(cur[15:8]) + 1);
      ws = wt * (int'(cur[31:16]) + 1);
      am = int'(cur[5:0]) + 1;
      at = am * (int'(cur[31:16]) + 1);
      for (int i = 0; i < cycles; i++) begin
         check(w_main, due(wm), (wm == 1) ? "R3 wide main" : "R2 wide main");
         check(w_us,   due(wt), "R4 wide settle");
         check(w_ms,   due(ws), "R5 wide wait");
         check(n_main, due(am), "R2 narrow main");
         check(n_us,   due(at), "R4 narrow settle");
         check(n_ms,   1'b0,    "R7 narrow wait");
         @(negedge clk);
         n++;
      end
   endtask

   task automatic wr(input logic [31:0] v);
      cfg_wr   = 1'b1;
      cfg_data = v;
      @(negedge clk);
      cfg_wr   = 1'b0;
      cur      = v;
      n        = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: quiet during reset
      check(w_main | w_us | w_ms, 1'b0, "R1 wide reset");
      check(n_main | n_us | n_ms, 1'b0, "R1 narrow reset");
      rst_n = 1'b1;
      @(negedge clk);
      cur = '0;
      n   = 0;
      run(6);   // R1 and R3: cleared word divides by one everywhere

      // R2/R4/R5/R6: sweep of small ratios, written back to back mid-phase
      for (int s = 0; s < 3; s++)
         for (int t = 0; t < 4; t++)
            for (int m = 0; m < 4; m++) begin
               wr((32'(s) << 16) | (32'(t) << 8) | 32'(m));
               run(2 * (m + 1) * (t + 1) * (s + 1) + 3);
            end

      // R6: rewrite the same word while counters are mid-count
      wr(32'h0001_0102);
      run(4);
      wr(32'h0001_0102);
      run(30);

      // R8: largest main ratios (256 wide, 64 narrow)
      wr(32'h0000_00FF);
      run(520);

      // R7: narrow reserved bits 15:6 set; wide decodes them as settle
      wr(32'h0001_3F42);
      run(9000);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule